// File: doc/BRIEF.md
# Snooping Write-Back Cache Controller

This block is the private data-cache controller of one processor on a small shared-bus multiprocessor. It holds a direct-mapped, write-back cache of one-word lines. Each line carries a tag and three state bits: valid, dirty and shared. Coherence follows a write-invalidate snooping scheme. The processor issues word reads and writes over a request/ready handshake. The controller takes the shared bus through an external request/grant arbiter and issues read, read-for-ownership, invalidate and writeback transactions. A snoop port watches the transactions of the other masters.

Two tag/state copies are kept with identical contents. The processor looks up the primary copy and the snoop logic looks up the duplicate, so both lookups happen in the same cycle. Every state change is written to both copies through one shared write port. When a snoop hit has to change a line's state, it takes that port and the processor waits one cycle. A snoop hit on a dirty line makes this controller supply the word and raise a cancel signal that suppresses the memory response. A snoop read hit raises a shared response, so the requesting cache installs the line as shared rather than private.

Top module: `snoop_wb_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses. `bus_req`, `cpu_ready`, `snp_shared_o` and `snp_cancel_o` are low during reset.
- R2: A read that hits asserts `cpu_ready` in the same cycle as `cpu_req`, with the stored word on `cpu_rdata`, and starts no bus transaction.
- R3: A read miss issues a READ transaction (`bus_cmd_o` = 0) on the cycle the bus is granted, then returns the response word. The line is installed shared if `bus_shared_i` is high with the response, and private otherwise.
- R4: A write that hits a valid line that is not shared completes in the request cycle with no bus transaction. The line becomes dirty.
- R5: A write that hits a shared line stalls until `bus_gnt`, with `cpu_ready` held low. In the grant cycle it issues INVALIDATE (`bus_cmd_o` = 2) for the address and completes. The line becomes private, so a following write to it needs no bus traffic.
- R6: A write miss issues a read-for-ownership (`bus_cmd_o` = 1) and installs the fetched line. The write is then applied, leaving the line dirty and private.
- R7: A miss whose victim line is dirty first issues WRITEBACK (`bus_cmd_o` = 3), carrying the victim's address and word, and only then the fill. A clean victim is overwritten with no writeback.
- R8: A snoop READ (`snp_cmd` = 0) or read-for-ownership (`snp_cmd` = 1) that hits a dirty line raises `snp_cancel_o` one cycle later. In that same cycle `snp_data_o` carries the line's word.
- R9: A snoop READ hit raises `snp_shared_o` one cycle later. A private line that it hits becomes shared.
- R10: A snoop INVALIDATE (`snp_cmd` = 2) or read-for-ownership that hits a line clears its valid bit, so the next processor access to that address misses.
- R11: A snoop that misses in the cache, or any snoop WRITEBACK (`snp_cmd` = 3), produces no response and changes no line state.
- R12: The processor is stalled (`cpu_ready` low) only in a cycle where a snoop hit changes a line's state. A snoop hit that changes no state does not delay a processor hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DW | Read data, valid with cpu_ready |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_valid_o | output | 1 | A transaction is placed on the bus this cycle |
| bus_cmd_o | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 writeback |
| bus_addr_o | output | AW | Transaction address |
| bus_wdata_o | output | DW | Writeback data |
| bus_rvalid_i | input | 1 | Fill response valid |
| bus_rdata_i | input | DW | Fill response word |
| bus_shared_i | input | 1 | Another cache holds the line, sampled with the response |
| snp_valid | input | 1 | Another master's transaction is visible |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd_o |
| snp_addr | input | AW | Snooped address |
| snp_shared_o | output | 1 | Shared response, one cycle after the snoop |
| snp_cancel_o | output | 1 | Cancel the memory response, one cycle after the snoop |
| snp_data_o | output | DW | Word supplied by this cache with snp_cancel_o |

## Verification
A hit and a write to a private line are due in the request cycle: the bench samples `cpu_ready` two time units after the falling edge on which it raised the request. For a miss, the bench's bus model grants on the falling edge after it sees `bus_req`, and the grant and the transaction fields are sampled one unit after that edge. The model answers a fill two falling edges after the grant, and the bench expects `cpu_ready` one cycle after the response, because the install stage sits between them. Snoop responses are registered, so they are sampled on the falling edge after the snoop cycle. Stall and serialization checks count `cpu_ready` on each individual cycle while a snoop update is applied or the grant is withheld.

// File: rtl/snc_pkg.sv
package snc_pkg;

  typedef enum logic [1:0] {
    BUS_RD  = 2'd0,
    BUS_RDX = 2'd1,
    BUS_INV = 2'd2,
    BUS_WB  = 2'd3
  } bus_cmd_e;

  typedef struct packed {
    logic v;
    logic d;
    logic s;
  } line_flags_t;

  // Decide which bus transaction an access needs: {need, cmd}
  function automatic logic [2:0] plan_access(logic hit, logic we, line_flags_t f);
    logic [2:0] r;
    if (hit) begin
      if (we && f.s) r = {1'b1, BUS_INV};
      else           r = {1'b0, BUS_RD};
    end else if (f.v && f.d) begin
      r = {1'b1, BUS_WB};
    end else begin
      r = {1'b1, (we ? BUS_RDX : BUS_RD)};
    end
    return r;
  endfunction

  // State a snoop leaves behind on a hit line
  function automatic line_flags_t snoop_next(logic [1:0] cmd, line_flags_t f);
    line_flags_t n;
    n = f;
    case (cmd)
      BUS_RD:  n.s = 1'b1;
      BUS_RDX,
      BUS_INV: n = '0;
      default: n = f;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/snc_tag_array.sv
module snc_tag_array
  import snc_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ridx,
  output logic [TAG_W-1:0] rtag,
  output line_flags_t      rflags,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [TAG_W-1:0] wtag,
  input  line_flags_t      wflags
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] tags  [DEPTH];
  line_flags_t      flags [DEPTH];

  assign rtag   = tags[ridx];
  assign rflags = flags[ridx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        tags[i]  <= '0;
        flags[i] <= '0;
      end
    end else if (we) begin
      tags[widx]  <= wtag;
      flags[widx] <= wflags;
    end
  end
endmodule

// File: rtl/snc_data_array.sv
module snc_data_array #(
  parameter int DW    = 16,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cidx,
  output logic [DW-1:0]    cdata,
  input  logic [IDX_W-1:0] sidx,
  output logic [DW-1:0]    sdata,
  input  logic             we,
  input  logic [DW-1:0]    wdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] words [DEPTH];

  assign cdata = words[cidx];
  assign sdata = words[sidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (we) begin
      words[cidx] <= wdata;
    end
  end
endmodule

// File: rtl/snc_snoop.sv
module snc_snoop
  import snc_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snp_valid,
  input  logic [1:0]       snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [TAG_W-1:0] dup_tag,
  input  line_flags_t      dup_flags,
  input  logic [DW-1:0]    line_data,
  output logic             snp_hit,
  output logic             snp_upd,
  output line_flags_t      snp_flags,
  output logic             shared_o,
  output logic             cancel_o,
  output logic [DW-1:0]    data_o
);
  logic supply;

  assign snp_hit   = snp_valid && dup_flags.v && (dup_tag == snp_tag);
  assign snp_flags = snoop_next(snp_cmd, dup_flags);
  assign snp_upd   = snp_hit && (snp_flags != dup_flags);
  assign supply    = snp_hit && dup_flags.d &&
                     (snp_cmd == BUS_RD || snp_cmd == BUS_RDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shared_o <= 1'b0;
      cancel_o <= 1'b0;
      data_o   <= '0;
    end else begin
      shared_o <= snp_hit && (snp_cmd == BUS_RD);
      cancel_o <= supply;
      data_o   <= supply ? line_data : '0;
    end
  end
endmodule

// File: rtl/snoop_wb_cache.sv
module snoop_wb_cache
  import snc_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int IDX_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_valid_o,
  output logic [1:0]    bus_cmd_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_rvalid_i,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_shared_i,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_shared_o,
  output logic          snp_cancel_o,
  output logic [DW-1:0] snp_data_o
);
  localparam int TAG_W = AW - IDX_W;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_FILL} st_e;

  st_e st, st_n;

  logic [IDX_W-1:0] cidx, sidx;
  logic [TAG_W-1:0] ctag, stag;
  assign cidx = cpu_addr[IDX_W-1:0];
  assign ctag = cpu_addr[AW-1:IDX_W];
  assign sidx = snp_addr[IDX_W-1:0];
  assign stag = snp_addr[AW-1:IDX_W];

  // primary lookup (processor side)
  logic [TAG_W-1:0] p_tag;
  line_flags_t      p_fl;
  // duplicate lookup (snoop side)
  logic [TAG_W-1:0] d_tag;
  line_flags_t      d_fl;

  logic [DW-1:0] c_data, s_data;

  // shared state write port
  logic             arr_we;
  logic [IDX_W-1:0] arr_idx;
  logic [TAG_W-1:0] arr_tag;
  line_flags_t      arr_flags;

  // processor-side write request
  logic             cpu_arr_we;
  logic [TAG_W-1:0] cpu_wtag;
  line_flags_t      cpu_wflags;
  logic             dat_we;
  logic [DW-1:0]    dat_wdata;

  // snoop events
  logic        snp_hit, snp_upd;
  line_flags_t snp_flags;

  // access decision
  logic        c_hit, need;
  bus_cmd_e    pcmd;
  logic [2:0]  plan;

  logic [DW-1:0] fill_data;
  logic          fill_sh;

  assign c_hit = p_fl.v && (p_tag == ctag);
  assign plan  = plan_access(c_hit, cpu_we, p_fl);
  assign need  = plan[2];
  assign pcmd  = bus_cmd_e'(plan[1:0]);

  // snoop updates own the write port; the processor waits
  assign arr_we    = snp_upd || cpu_arr_we;
  assign arr_idx   = snp_upd ? sidx      : cidx;
  assign arr_tag   = snp_upd ? d_tag     : cpu_wtag;
  assign arr_flags = snp_upd ? snp_flags : cpu_wflags;

  snc_tag_array #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_prim (
    .clk(clk), .rst_n(rst_n), .ridx(cidx), .rtag(p_tag), .rflags(p_fl),
    .we(arr_we), .widx(arr_idx), .wtag(arr_tag), .wflags(arr_flags)
  );

  snc_tag_array #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_dup (
    .clk(clk), .rst_n(rst_n), .ridx(sidx), .rtag(d_tag), .rflags(d_fl),
    .we(arr_we), .widx(arr_idx), .wtag(arr_tag), .wflags(arr_flags)
  );

  snc_data_array #(.DW(DW), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rst_n(rst_n), .cidx(cidx), .cdata(c_data),
    .sidx(sidx), .sdata(s_data), .we(dat_we), .wdata(dat_wdata)
  );

  snc_snoop #(.TAG_W(TAG_W), .DW(DW)) u_snoop (
    .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_tag(stag), .dup_tag(d_tag), .dup_flags(d_fl), .line_data(s_data),
    .snp_hit(snp_hit), .snp_upd(snp_upd), .snp_flags(snp_flags),
    .shared_o(snp_shared_o), .cancel_o(snp_cancel_o), .data_o(snp_data_o)
  );

  assign bus_cmd_o   = pcmd;
  assign bus_addr_o  = (pcmd == BUS_WB) ? {p_tag, cidx} : cpu_addr;
  assign bus_wdata_o = c_data;
  assign cpu_rdata   = (st == ST_FILL) ? fill_data : c_data;

  always_comb begin
    st_n        = st;
    cpu_ready   = 1'b0;
    bus_req     = 1'b0;
    bus_valid_o = 1'b0;
    cpu_arr_we  = 1'b0;
    cpu_wtag    = p_tag;
    cpu_wflags  = p_fl;
    dat_we      = 1'b0;
    dat_wdata   = cpu_wdata;
    case (st)
      ST_IDLE: begin
        if (cpu_req && !snp_upd) begin
          if (!need) begin
            cpu_ready = 1'b1;
            if (cpu_we) begin
              cpu_arr_we = 1'b1;
              cpu_wflags = '{v: 1'b1, d: 1'b1, s: 1'b0};
              dat_we     = 1'b1;
            end
          end else begin
            st_n = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (!need) begin
          st_n = ST_IDLE;
        end else begin
          bus_req = 1'b1;
          if (bus_gnt && !snp_upd) begin
            bus_valid_o = 1'b1;
            case (pcmd)
              BUS_INV: begin
                cpu_ready  = 1'b1;
                cpu_arr_we = 1'b1;
                cpu_wflags = '{v: 1'b1, d: 1'b1, s: 1'b0};
                dat_we     = 1'b1;
                st_n       = ST_IDLE;
              end
              BUS_WB: begin
                cpu_arr_we = 1'b1;
                cpu_wflags = '0;
              end
              default: st_n = ST_WAIT;
            endcase
          end
        end
      end
      ST_WAIT: begin
        if (bus_rvalid_i) st_n = ST_FILL;
      end
      default: begin
        if (!snp_upd) begin
          cpu_ready  = 1'b1;
          cpu_arr_we = 1'b1;
          cpu_wtag   = ctag;
          cpu_wflags = '{v: 1'b1, d: cpu_we, s: fill_sh};
          dat_we     = 1'b1;
          dat_wdata  = cpu_we ? cpu_wdata : fill_data;
          st_n       = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      fill_data <= '0;
      fill_sh   <= 1'b0;
    end else begin
      st <= st_n;
      if (st == ST_WAIT && bus_rvalid_i) begin
        fill_data <= bus_rdata_i;
        fill_sh   <= bus_shared_i && !cpu_we;
      end
    end
  end
endmodule

// File: rtl/snc_checker.sv
module snc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_ready,
  input logic       cpu_we,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       bus_valid_o,
  input logic [1:0] bus_cmd_o,
  input logic       snp_valid,
  input logic [1:0] snp_cmd,
  input logic       snp_shared_o,
  input logic       snp_cancel_o,
  input logic       snp_upd,
  input logic       cpu_arr_we
);
  a_r12_stall_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    snp_upd |-> !cpu_ready);

  a_r12_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_upd && cpu_arr_we));

  a_r5_inv_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && bus_cmd_o == 2'd2) |-> (cpu_ready && cpu_we));

  a_r7_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && bus_cmd_o == 2'd3) |=> bus_req);

  a_r3_granted_only: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o |-> (bus_gnt && bus_req));

  a_r9_shared_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared_o |-> $past(snp_valid && snp_cmd == 2'd0));

  a_r8_cancel_follows_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    snp_cancel_o |-> $past(snp_valid && (snp_cmd == 2'd0 || snp_cmd == 2'd1)));
endmodule

bind snoop_wb_cache snc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid_o(bus_valid_o),
  .bus_cmd_o(bus_cmd_o), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
  .snp_shared_o(snp_shared_o), .snp_cancel_o(snp_cancel_o),
  .snp_upd(snp_upd), .cpu_arr_we(cpu_arr_we)
);

// File: tb/snoop_wb_cache_test.sv
module snoop_wb_cache_test;
  localparam int AW = 8, DW = 16, IDX_W = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req, bus_valid_o;
  logic          bus_gnt = 0, bus_rvalid_i = 0, bus_shared_i = 0;
  logic [1:0]    bus_cmd_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o, bus_rdata_i = '0;
  logic          snp_valid = 0;
  logic [1:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_shared_o, snp_cancel_o;
  logic [DW-1:0] snp_data_o;

  snoop_wb_cache #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) uut (.*);

  int checks = 0, errors = 0;
  logic [DW-1:0] mem [256];
  bit gnt_en = 1, other_sh = 0;
  int rv_cnt = 0;
  logic [DW-1:0] rv_data;
  int log_n = 0;
  logic [1:0]    log_cmd  [4];
  logic [AW-1:0] log_addr [4];
  logic [DW-1:0] log_wd   [4];

  function automatic logic [DW-1:0] fmem(int a);
    return DW'(a * 257) ^ 16'h5a5a;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // bus model: arbiter, memory and responder
  always @(negedge clk) begin
    bus_rvalid_i = 1'b0;
    bus_shared_i = 1'b0;
    if (rv_cnt > 0) begin
      rv_cnt--;
      if (rv_cnt == 0) begin
        bus_rvalid_i = 1'b1;
        bus_rdata_i  = rv_data;
        bus_shared_i = other_sh;
      end
    end
    bus_gnt = bus_req & gnt_en;
    #1;
    if (bus_valid_o) begin
      if (log_n < 4) begin
        log_cmd[log_n]  = bus_cmd_o;
        log_addr[log_n] = bus_addr_o;
        log_wd[log_n]   = bus_wdata_o;
      end
      log_n++;
      if (bus_cmd_o == 2'd3) mem[bus_addr_o] = bus_wdata_o;
      if (bus_cmd_o < 2'd2) begin
        rv_cnt  = 2;
        rv_data = mem[bus_addr_o];
      end
    end
  end

  task automatic cpu_op(bit we, logic [AW-1:0] a, logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int waits);
    @(negedge clk);
    log_n = 0;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    waits = 0;
    forever begin
      #2;
      if (cpu_ready) break;
      waits++;
      @(negedge clk);
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 0;
  endtask

  task automatic access(string tag, bit we, logic [AW-1:0] a, logic [DW-1:0] wd,
                        int exp_rd, int exp_n);
    logic [DW-1:0] rd;
    int w;
    cpu_op(we, a, wd, rd, w);
    if (!we) chk(tag, "read data", rd, exp_rd);
    chk(tag, "bus transactions", log_n, exp_n);
    if (exp_n == 0) chk(tag, "wait cycles", w, 0);
  endtask

  task automatic snoop(logic [1:0] c, logic [AW-1:0] a,
                       output logic sh, output logic cn, output logic [DW-1:0] d);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_valid = 0;
    #2;
    sh = snp_shared_o; cn = snp_cancel_o; d = snp_data_o;
  endtask

  task automatic snoop_chk(string tag, logic [1:0] c, logic [AW-1:0] a,
                           int esh, int ecn, int ed);
    logic sh, cn;
    logic [DW-1:0] d;
    snoop(c, a, sh, cn, d);
    chk(tag, "shared response", sh, esh);
    chk(tag, "cancel", cn, ecn);
    if (ecn) chk(tag, "supplied data", d, ed);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rdy;
    for (int a = 0; a < 256; a++) mem[a] = fmem(a);
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1", "bus_req in reset", bus_req, 0);
    chk("R1", "cpu_ready in reset", cpu_ready, 0);
    chk("R1", "snp_shared_o in reset", snp_shared_o, 0);
    chk("R1", "snp_cancel_o in reset", snp_cancel_o, 0);
    rst_n = 1;

    // R1/R3: every index misses after reset; READ issued
    for (int i = 0; i < 4; i++) begin
      access("R3", 0, AW'(8'h10 + i), '0, fmem(8'h10 + i), 1);
      chk("R3", "command READ", log_cmd[0], 0);
      chk("R1", "miss address", log_addr[0], 8'h10 + i);
    end
    // R2: hits
    for (int i = 0; i < 4; i++) access("R2", 0, AW'(8'h10 + i), '0, fmem(8'h10 + i), 0);

    // R4: private write completes locally
    access("R4", 1, 8'h10, 16'hBEEF, 0, 0);
    access("R4", 0, 8'h10, '0, 16'hBEEF, 0);

    // R8/R9: snoop read of dirty and clean private lines
    snoop_chk("R8", 2'd0, 8'h10, 1, 1, 16'hBEEF);
    snoop_chk("R9", 2'd0, 8'h11, 1, 0, 0);

    // R5: write to shared line invalidates, then private
    access("R5", 1, 8'h11, 16'h1111, 0, 1);
    chk("R5", "command INV", log_cmd[0], 2);
    chk("R5", "INV address", log_addr[0], 8'h11);
    access("R5", 1, 8'h11, 16'h2222, 0, 0);
    access("R9", 1, 8'h10, 16'h3333, 0, 1);
    chk("R9", "dirty shared write INV", log_cmd[0], 2);

    // R10: snoop invalidate and read-for-ownership
    snoop_chk("R10", 2'd2, 8'h12, 0, 0, 0);
    access("R10", 0, 8'h12, '0, fmem(8'h12), 1);
    snoop_chk("R8", 2'd1, 8'h11, 0, 1, 16'h2222);
    access("R10", 0, 8'h11, '0, fmem(8'h11), 1);

    // R11: snoop writeback and snoop miss ignored
    snoop_chk("R11", 2'd3, 8'h13, 0, 0, 0);
    snoop_chk("R11", 2'd0, 8'h93, 0, 0, 0);
    access("R11", 1, 8'h13, 16'h4444, 0, 0);

    // R7: dirty victim written back before fill; clean victim not
    access("R7", 0, 8'h93, '0, fmem(8'h93), 2);
    chk("R7", "first command WB", log_cmd[0], 3);
    chk("R7", "WB address", log_addr[0], 8'h13);
    chk("R7", "WB data", log_wd[0], 16'h4444);
    chk("R7", "second command READ", log_cmd[1], 0);
    chk("R7", "fill address", log_addr[1], 8'h93);
    access("R7", 0, 8'h52, '0, fmem(8'h52), 1);

    // R6: write miss with dirty victim
    access("R6", 1, 8'h20, 16'h5555, 0, 2);
    chk("R6", "victim WB", log_cmd[0], 3);
    chk("R6", "victim data", log_wd[0], 16'h3333);
    chk("R6", "command RDX", log_cmd[1], 1);
    chk("R6", "RDX address", log_addr[1], 8'h20);
    access("R6", 0, 8'h20, '0, 16'h5555, 0);
    snoop_chk("R6", 2'd0, 8'h20, 1, 1, 16'h5555);

    // R3: fill seen as shared installs shared
    other_sh = 1;
    access("R3", 0, 8'h61, '0, fmem(8'h61), 1);
    other_sh = 0;
    access("R3", 1, 8'h61, 16'h6666, 0, 1);
    chk("R3", "shared install needs INV", log_cmd[0], 2);

    // R5: write to shared line waits for grant
    snoop_chk("R9", 2'd0, 8'h61, 1, 1, 16'h6666);
    gnt_en = 0;
    @(negedge clk);
    log_n = 0;
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h61; cpu_wdata = 16'h7777;
    rdy = 0;
    repeat (6) begin
      #2;
      rdy += int'(cpu_ready);
      @(negedge clk);
    end
    #2;
    chk("R5", "ready while not granted", rdy, 0);
    chk("R5", "bus_req held", bus_req, 1);
    gnt_en = 1;
    forever begin
      @(negedge clk);
      #2;
      if (cpu_ready) break;
    end
    @(negedge clk);
    cpu_req = 0;
    chk("R5", "transactions after grant", log_n, 1);
    chk("R5", "granted command INV", log_cmd[0], 2);
    access("R5", 0, 8'h61, '0, 16'h7777, 0);

    // R12: snoop update stalls a hit for one cycle
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h20;
    snp_valid = 1; snp_cmd = 2'd2; snp_addr = 8'h52;
    #2;
    chk("R12", "ready during snoop update", cpu_ready, 0);
    @(negedge clk);
    snp_valid = 0;
    #2;
    chk("R12", "ready after update", cpu_ready, 1);
    chk("R12", "data after update", cpu_rdata, 16'h5555);
    @(negedge clk);
    cpu_req = 0;
    access("R10", 0, 8'h52, '0, fmem(8'h52), 1);

    // R12: snoop hit with no state change does not stall
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h20;
    snp_valid = 1; snp_cmd = 2'd0; snp_addr = 8'h20;
    #2;
    chk("R12", "ready with parallel snoop", cpu_ready, 1);
    @(negedge clk);
    cpu_req = 0; snp_valid = 0;
    #2;
    chk("R9", "shared response on shared line", snp_shared_o, 1);
    chk("R8", "dirty shared line supplies", snp_data_o, 16'h5555);

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule